// File: doc/BRIEF.md
# Pipeline Bubble Accounting Monitor

This block sits beside an in-order pipeline and accounts for every clock cycle as either a completed instruction or an injected bubble. Each cycle it takes a retire strobe and three hazard strobes: a load-use stall, a mispredicted conditional branch and a return. A hazard strobe is charged a fixed number of bubbles for its cause. Saturating counters hold the total cycles, the completed instructions, the total bubbles and the bubbles of each cause.

A clear input zeroes every counter and every sticky flag. A freeze input holds all counters together, so a snapshot stays self-consistent while it is read. A sequential restoring divider, started by a start/done handshake, returns either the cycles-per-instruction figure or the penalty per instruction of one cause. Results are unsigned fixed point. When a division is accepted, the monitor checks that the cycle count equals instructions plus bubbles. A mismatch raises a sticky error.

The divider controller has three states. `DV_IDLE` waits for a start. Transition START_RUN goes to `DV_RUN` when the divisor is non-zero. Transition START_ZERO goes straight to `DV_DONE` when the divisor is zero. In `DV_RUN` the transition STEP stays in place for one quotient bit per cycle, and LAST_STEP moves to `DV_DONE` after the final bit. Transition RETIRE_RESULT returns from `DV_DONE` to `DV_IDLE` after one cycle.

Top module: `bubble_acct_top`

## Requirements
- R1: Unless frozen or cleared, the cycle counter increments every cycle, and the instruction counter increments in each cycle where `retire` is high.
- R2: A load-use strobe adds 1 bubble, a mispredict strobe adds 2 and a return strobe adds 3. Each cause has its own counter. The total bubble counter adds the sum of the charges in that cycle.
- R3: Every counter stops at its all-ones value instead of wrapping. `count_overflow` is then set and stays set until a clear.
- R4: When `clr` is high, all counters, `count_overflow` and `consist_err` read zero on the next cycle, whatever the strobe and freeze inputs are.
- R5: While `freeze` is high, every counter holds its value regardless of the strobes.
- R6: On an accepted start with `count_overflow` low, `consist_err` is set if cycles differ from instructions plus bubbles. It then stays set until a clear.
- R7: `div_sel` picks the result: 0 gives 1.0 + bubbles/instructions, 1 gives load-use bubbles per instruction, 2 gives mispredict bubbles per instruction and 3 gives return bubbles per instruction. The result is unsigned, truncated, with FRAC_W fractional bits, and saturates at all ones.
- R8: If the instruction count is zero at an accepted start, the result is zero and `div_invalid` is high. `div_invalid` keeps the value from the latest accepted start.
- R9: `div_busy` is high from the cycle after an accepted start until `div_done`. `div_done` is high for exactly one cycle per accepted start. A start while busy is ignored.
- R10: After reset, all counters, flags, `div_busy`, `div_done` and `div_result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and sticky flags |
| freeze | input | 1 | Hold all counters |
| retire | input | 1 | One instruction completed this cycle |
| ev_load_use | input | 1 | Load-use stall event |
| ev_mispredict | input | 1 | Mispredicted conditional branch event |
| ev_return | input | 1 | Return instruction event |
| div_start | input | 1 | Request a division |
| div_sel | input | 2 | Ratio select (0 CPI, 1 load-use, 2 mispredict, 3 return) |
| cycle_count | output | CNT_W | Total cycles |
| instr_count | output | CNT_W | Completed instructions |
| bubble_count | output | CNT_W | Total bubbles |
| load_use_bubbles | output | CNT_W | Load-use bubbles |
| mispredict_bubbles | output | CNT_W | Mispredict bubbles |
| return_bubbles | output | CNT_W | Return bubbles |
| count_overflow | output | 1 | Sticky saturation flag |
| consist_err | output | 1 | Sticky identity mismatch flag |
| div_busy | output | 1 | Division in progress |
| div_done | output | 1 | One-cycle result strobe |
| div_invalid | output | 1 | Last accepted division had a zero divisor |
| div_result | output | CNT_W+FRAC_W | Fixed-point quotient |

## Verification
Clear and counting can fall in the same cycle. The bench raises `clr` together with `retire`, all three hazard strobes and after a consistency error, then expects zero counters and zero flags on the next cycle. A second start can also arrive while a division is running. The bench pulses `div_start` with a different selector a few cycles into a division. It then expects a single `div_done` pulse that carries the quotient for the first selector. A sweep over every combination of zero to three events per cause compares the counters and all four ratios against values computed arithmetically.

// File: rtl/bubble_acct_pkg.sv
package bubble_acct_pkg;
    localparam int NUM_CAUSE = 3;
    localparam int CAUSE_LU  = 0;
    localparam int CAUSE_BR  = 1;
    localparam int CAUSE_RET = 2;
    localparam int COST_W    = 2;
    localparam int TOT_W     = 3;

    typedef enum logic [1:0] {
        SEL_CPI = 2'd0,
        SEL_LU  = 2'd1,
        SEL_BR  = 2'd2,
        SEL_RET = 2'd3
    } ratio_sel_e;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_DONE = 2'd2
    } div_state_e;

    function automatic logic [COST_W-1:0] cause_cost(input int idx);
        case (idx)
            CAUSE_LU: return 2'd1;
            CAUSE_BR: return 2'd2;
            default:  return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W     = 32,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt,
    output logic             ovf
);
    logic [W:0] inc_ext;
    logic [W:0] sum;

    assign inc_ext = {{(W + 1 - INC_W){1'b0}}, inc};
    assign sum     = {1'b0, cnt} + inc_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (en) begin
            if (sum[W]) begin
                cnt <= '1;
                ovf <= 1'b1;
            end else begin
                cnt <= sum[W-1:0];
            end
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> cnt >= $past(cnt)); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf); // R3
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !ovf)); // R4
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt)); // R5
endmodule

// File: rtl/bubble_charger.sv
module bubble_charger
    import bubble_acct_pkg::*;
(
    input  logic [NUM_CAUSE-1:0]             ev,
    output logic [NUM_CAUSE-1:0][COST_W-1:0] cause_inc,
    output logic [TOT_W-1:0]                 total_inc
);
    for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
        assign cause_inc[g] = ev[g] ? cause_cost(g) : '0;
    end

    always_comb begin
        total_inc = '0;
        for (int i = 0; i < NUM_CAUSE; i++) begin
            total_inc = total_inc + TOT_W'(cause_inc[i]);
        end
    end
endmodule

// File: rtl/frac_divider.sv
module frac_divider
    import bubble_acct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int FRAC_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      add_one,
    input  logic [CNT_W-1:0]          num,
    input  logic [CNT_W-1:0]          den,
    output logic                      busy,
    output logic                      done,
    output logic                      invalid,
    output logic [CNT_W+FRAC_W-1:0]   result
);
    localparam int Q_W    = CNT_W + FRAC_W;
    localparam int STEP_W = $clog2(Q_W + 1);
    localparam logic [Q_W:0] ONE_FX = {{Q_W{1'b0}}, 1'b1} << FRAC_W;

    div_state_e         state_q, state_d;
    logic [Q_W-1:0]     dvd_q;
    logic [CNT_W-1:0]   den_q;
    logic [CNT_W:0]     rem_q;
    logic [Q_W-1:0]     quo_q;
    logic [STEP_W-1:0]  step_q;
    logic               add_q;
    logic               inv_q;
    logic [Q_W-1:0]     res_q;

    logic [CNT_W:0]     trial;
    logic               fits;
    logic [CNT_W:0]     rem_nx;
    logic [Q_W-1:0]     quo_nx;
    logic [Q_W:0]       sum_w;
    logic [Q_W-1:0]     res_nx;

    // Next-state logic: START_RUN, START_ZERO, STEP, LAST_STEP, RETIRE_RESULT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DV_IDLE: if (start) state_d = (den == '0) ? DV_DONE : DV_RUN;
            DV_RUN:  if (step_q == STEP_W'(1)) state_d = DV_DONE;
            DV_DONE: state_d = DV_IDLE;
            default: state_d = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DV_IDLE;
        else        state_q <= state_d;
    end

    // One restoring step
    always_comb begin
        trial  = {rem_q[CNT_W-1:0], dvd_q[Q_W-1]};
        fits   = trial >= {1'b0, den_q};
        rem_nx = fits ? (trial - {1'b0, den_q}) : trial;
        quo_nx = {quo_q[Q_W-2:0], fits};
        sum_w  = {1'b0, quo_nx} + (add_q ? ONE_FX : '0);
        res_nx = sum_w[Q_W] ? '1 : sum_w[Q_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            den_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            step_q <= '0;
            add_q  <= 1'b0;
            inv_q  <= 1'b0;
            res_q  <= '0;
        end else begin
            unique case (state_q)
                DV_IDLE: if (start) begin
                    dvd_q  <= {num, {FRAC_W{1'b0}}};
                    den_q  <= den;
                    rem_q  <= '0;
                    quo_q  <= '0;
                    step_q <= STEP_W'(Q_W);
                    add_q  <= add_one;
                    inv_q  <= (den == '0);
                    if (den == '0) res_q <= '0;
                end
                DV_RUN: begin
                    dvd_q  <= dvd_q << 1;
                    rem_q  <= rem_nx;
                    quo_q  <= quo_nx;
                    step_q <= step_q - STEP_W'(1);
                    if (step_q == STEP_W'(1)) res_q <= res_nx;
                end
                default: ;
            endcase
        end
    end

    // Output process
    always_comb begin
        busy    = (state_q != DV_IDLE);
        done    = (state_q == DV_DONE);
        invalid = inv_q;
        result  = res_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DV_RUN) |=> $stable(den_q)); // R9
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && invalid) |-> (result == '0)); // R8
endmodule

// File: rtl/bubble_acct_top.sv
module bubble_acct_top
    import bubble_acct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    freeze,
    input  logic                    retire,
    input  logic                    ev_load_use,
    input  logic                    ev_mispredict,
    input  logic                    ev_return,
    input  logic                    div_start,
    input  logic [1:0]              div_sel,
    output logic [CNT_W-1:0]        cycle_count,
    output logic [CNT_W-1:0]        instr_count,
    output logic [CNT_W-1:0]        bubble_count,
    output logic [CNT_W-1:0]        load_use_bubbles,
    output logic [CNT_W-1:0]        mispredict_bubbles,
    output logic [CNT_W-1:0]        return_bubbles,
    output logic                    count_overflow,
    output logic                    consist_err,
    output logic                    div_busy,
    output logic                    div_done,
    output logic                    div_invalid,
    output logic [CNT_W+FRAC_W-1:0] div_result
);
    localparam int NUM_BASE = 3;

    logic [NUM_CAUSE-1:0]             ev_vec;
    logic [NUM_CAUSE-1:0][COST_W-1:0] cause_inc;
    logic [TOT_W-1:0]                 total_inc;
    logic [NUM_CAUSE-1:0][CNT_W-1:0]  cause_cnt;
    logic [NUM_CAUSE-1:0]             cause_ovf;
    logic [NUM_BASE-1:0]              base_ovf;
    logic                             cnt_en;
    logic [CNT_W-1:0]                 numer;
    logic                             accept;
    logic [CNT_W:0]                   expect_cyc;

    assign ev_vec = {ev_return, ev_mispredict, ev_load_use};
    assign cnt_en = !freeze;

    bubble_charger u_charger (
        .ev        (ev_vec),
        .cause_inc (cause_inc),
        .total_inc (total_inc)
    );

    sat_counter #(.W(CNT_W), .INC_W(1)) u_cyc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(cnt_en),
        .inc(1'b1), .cnt(cycle_count), .ovf(base_ovf[0])
    );

    sat_counter #(.W(CNT_W), .INC_W(1)) u_ins (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(cnt_en),
        .inc(retire), .cnt(instr_count), .ovf(base_ovf[1])
    );

    sat_counter #(.W(CNT_W), .INC_W(TOT_W)) u_bub (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(cnt_en),
        .inc(total_inc), .cnt(bubble_count), .ovf(base_ovf[2])
    );

    for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause_cnt
        sat_counter #(.W(CNT_W), .INC_W(COST_W)) u_cause (
            .clk(clk), .rst_n(rst_n), .clr(clr), .en(cnt_en),
            .inc(cause_inc[g]), .cnt(cause_cnt[g]), .ovf(cause_ovf[g])
        );
    end

    assign load_use_bubbles   = cause_cnt[CAUSE_LU];
    assign mispredict_bubbles = cause_cnt[CAUSE_BR];
    assign return_bubbles     = cause_cnt[CAUSE_RET];
    assign count_overflow     = |base_ovf || |cause_ovf;

    always_comb begin
        unique case (ratio_sel_e'(div_sel))
            SEL_CPI: numer = bubble_count;
            SEL_LU:  numer = cause_cnt[CAUSE_LU];
            SEL_BR:  numer = cause_cnt[CAUSE_BR];
            SEL_RET: numer = cause_cnt[CAUSE_RET];
            default: numer = bubble_count;
        endcase
    end

    frac_divider #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (div_start),
        .add_one (div_sel == SEL_CPI),
        .num     (numer),
        .den     (instr_count),
        .busy    (div_busy),
        .done    (div_done),
        .invalid (div_invalid),
        .result  (div_result)
    );

    assign accept     = div_start && !div_busy;
    assign expect_cyc = {1'b0, instr_count} + {1'b0, bubble_count};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            consist_err <= 1'b0;
        end else if (clr) begin
            consist_err <= 1'b0;
        end else if (accept && !count_overflow && ({1'b0, cycle_count} != expect_cyc)) begin
            consist_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (consist_err && !clr) |=> consist_err); // R6
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !consist_err); // R4
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> div_busy); // R9
endmodule

// File: tb/bubble_acct_top_tb_top.sv
module bubble_acct_top_tb_top;
    localparam int CW = 8;
    localparam int FW = 8;
    localparam int QW = CW + FW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, freeze = 1'b0, retire = 1'b0;
    logic ev_lu = 1'b0, ev_br = 1'b0, ev_rt = 1'b0;
    logic div_start = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [CW-1:0] cyc_c, ins_c, bub_c, lu_c, br_c, rt_c;
    logic ovf, cerr, busy, done, inval;
    logic [QW-1:0] res;

    int checks = 0;
    int fails = 0;
    int n_done;
    longint got_res;
    longint got_inv;

    always #5 clk = ~clk;

    bubble_acct_top #(.CNT_W(CW), .FRAC_W(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .freeze(freeze), .retire(retire),
        .ev_load_use(ev_lu), .ev_mispredict(ev_br), .ev_return(ev_rt),
        .div_start(div_start), .div_sel(div_sel),
        .cycle_count(cyc_c), .instr_count(ins_c), .bubble_count(bub_c),
        .load_use_bubbles(lu_c), .mispredict_bubbles(br_c), .return_bubbles(rt_c),
        .count_overflow(ovf), .consist_err(cerr),
        .div_busy(busy), .div_done(done), .div_invalid(inval), .div_result(res)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic l, input logic b, input logic t);
        retire = r; ev_lu = l; ev_br = b; ev_rt = t;
        @(negedge clk);
    endtask

    task automatic quiet();
        retire = 1'b0; ev_lu = 1'b0; ev_br = 1'b0; ev_rt = 1'b0;
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic run_div(input logic [1:0] sel, input bit poke, input logic [1:0] poke_sel);
        div_sel = sel;
        div_start = 1'b1;
        @(negedge clk);
        div_start = 1'b0;
        chk("R9 busy after start", busy, 1);
        n_done = 0;
        for (int i = 0; i < 40; i++) begin
            if (poke && i == 3) begin
                div_sel = poke_sel;
                div_start = 1'b1;
            end else begin
                div_start = 1'b0;
            end
            if (done) begin
                n_done++;
                got_res = res;
                got_inv = inval;
            end
            @(negedge clk);
        end
        div_start = 1'b0;
        chk("R9 single done pulse", n_done, 1);
        chk("R9 idle after done", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        longint ins, bub, base;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 cycles", cyc_c, 0);
        chk("R10 bubbles", bub_c, 0);
        chk("R10 flags", {ovf, cerr, busy, done, inval}, 0);
        chk("R10 result", res, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R7 R6: sweep all mixes of 0..3 events per cause
        for (int nl = 0; nl < 4; nl++) begin
            for (int nb = 0; nb < 4; nb++) begin
                for (int nr = 0; nr < 4; nr++) begin
                    freeze = 1'b0;
                    do_clear();
                    for (int k = 0; k < nl; k++) begin
                        cyc(1, 1, 0, 0); cyc(0, 0, 0, 0);
                    end
                    for (int k = 0; k < nb; k++) begin
                        cyc(1, 0, 1, 0); repeat (2) cyc(0, 0, 0, 0);
                    end
                    for (int k = 0; k < nr; k++) begin
                        cyc(1, 0, 0, 1); repeat (3) cyc(0, 0, 0, 0);
                    end
                    cyc(1, 0, 0, 0); cyc(1, 0, 0, 0);
                    freeze = 1'b1;
                    quiet();
                    ins = 2 + nl + nb + nr;
                    bub = nl + 2 * nb + 3 * nr;
                    chk("R1 instructions", ins_c, ins);
                    chk("R1 cycles", cyc_c, ins + bub);
                    chk("R2 total bubbles", bub_c, bub);
                    chk("R2 load-use bubbles", lu_c, nl);
                    chk("R2 mispredict bubbles", br_c, 2 * nb);
                    chk("R2 return bubbles", rt_c, 3 * nr);
                    run_div(2'd0, 0, 2'd0);
                    chk("R7 cpi", got_res, (bub * 256) / ins + 256);
                    run_div(2'd1, 0, 2'd0);
                    chk("R7 load-use penalty", got_res, (nl * 256) / ins);
                    run_div(2'd2, 0, 2'd0);
                    chk("R7 mispredict penalty", got_res, (2 * nb * 256) / ins);
                    run_div(2'd3, 0, 2'd0);
                    chk("R7 return penalty", got_res, (3 * nr * 256) / ins);
                    chk("R8 valid divisor", got_inv, 0);
                    chk("R6 no mismatch", cerr, 0);
                end
            end
        end

        // R9: start while busy is ignored (counters: 3 ins, 1 lu, 2 br)
        freeze = 1'b0;
        do_clear();
        cyc(1, 1, 0, 0); cyc(0, 0, 0, 0);
        cyc(1, 0, 1, 0); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0);
        freeze = 1'b1; quiet();
        run_div(2'd2, 1, 2'd1);
        chk("R9 ignored start keeps first selector", got_res, (2 * 256) / 3);

        // R5: freeze holds counters under activity
        base = cyc_c;
        repeat (5) cyc(1, 1, 1, 1);
        quiet();
        chk("R5 frozen cycles", cyc_c, base);
        chk("R5 frozen instructions", ins_c, 3);
        chk("R5 frozen bubbles", bub_c, 3);
        chk("R5 frozen return", rt_c, 0);

        // R8: zero instructions
        do_clear();
        run_div(2'd0, 0, 2'd0);
        chk("R8 zero result", got_res, 0);
        chk("R8 invalid flag", got_inv, 1);
        chk("R8 invalid holds", inval, 1);

        // R6: mismatch (cycles without instructions or bubbles)
        freeze = 1'b0;
        repeat (3) cyc(0, 0, 0, 0);
        freeze = 1'b1;
        run_div(2'd2, 0, 2'd0);
        chk("R6 mismatch flagged", cerr, 1);
        repeat (3) @(negedge clk);
        chk("R6 flag sticky", cerr, 1);

        // R4: clear wins over counting and freeze
        freeze = 1'b0;
        cyc(1, 1, 1, 1);
        clr = 1'b1; retire = 1'b1; ev_lu = 1'b1; ev_br = 1'b1; ev_rt = 1'b1;
        @(negedge clk);
        clr = 1'b0; freeze = 1'b1; quiet();
        chk("R4 cycles cleared", cyc_c, 0);
        chk("R4 instructions cleared", ins_c, 0);
        chk("R4 bubbles cleared", bub_c + lu_c + br_c + rt_c, 0);
        chk("R4 error cleared", cerr, 0);

        // R3: saturation and sticky overflow
        freeze = 1'b0;
        repeat (300) cyc(1, 0, 0, 0);
        freeze = 1'b1; quiet();
        chk("R3 cycles saturate", cyc_c, 255);
        chk("R3 instructions saturate", ins_c, 255);
        chk("R3 overflow flag", ovf, 1);
        freeze = 1'b0;
        repeat (4) cyc(1, 0, 0, 0);
        quiet();
        chk("R3 overflow sticky", ovf, 1);
        chk("R3 held at max", cyc_c, 255);
        do_clear();
        freeze = 1'b1;
        chk("R3 overflow cleared", ovf, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule